// File: doc/BRIEF.md
# Triggered Programmable-Width Pulse Generator

This block is a synchronous one-shot. A rising edge on the trigger input starts an output pulse. The pulse lasts for a number of clock cycles set by a 22-bit width word. The word is split into two fields. The upper field counts whole blocks of 64 cycles. The lower field adds single cycles on top. A separate loader supplies the word. The block samples it only when it accepts a trigger, so software can stage the next value while a pulse is still running.

The trigger and stop inputs may come from another clock domain. Each passes through a two-stage synchronizer before use. After a pulse ends, either at its full length or because the stop input cut it short, a fixed recovery window follows. Trigger edges that arrive during a pulse or during the recovery window are dropped, not queued. Both the pulse and its complement are driven out.

Top module: `trig_pulse_gen`

## Requirements
- R1: During reset and after it, with no trigger, `pulse_o` is 0 and `pulse_no` is 1.
- R2: When `trig_i` rises from low (held stable around clock edges), `pulse_o` is high after the third rising clock edge that follows.
- R3: The pulse lasts coarse*64 + fine clock cycles, where coarse = `width_i[21:6]` and fine = `width_i[5:0]`.
- R4: A width word of zero gives a pulse of exactly one cycle.
- R5: `width_i` is captured when a trigger is accepted. Changing it while a pulse is high does not change that pulse's length.
- R6: A new rising edge on `trig_i` while the pulse is high neither lengthens the pulse nor starts another pulse afterwards.
- R7: After a pulse ends, a recovery window of RECOV_CYC cycles (default 2) discards trigger edges. With the default, a trigger that rises in the pulse's final high cycle is discarded. A trigger that rises one cycle later starts a pulse after the usual three clock edges.
- R8: Raising `stop_i` while the pulse is high ends the pulse. `pulse_o` stays high for two more clock edges and is low after the third.
- R9: The same recovery window follows a stopped pulse. A trigger that rises in the last high cycle of a stopped pulse is discarded, and a later trigger is accepted normally.
- R10: Holding `trig_i` high never starts a second pulse; only a fresh low-to-high transition can.
- R11: `pulse_no` is always the complement of `pulse_o`.
- R12: Raising `stop_i` while no pulse is active has no effect on the next triggered pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Trigger, asynchronous; rising edge starts a pulse |
| stop_i | input | 1 | Early termination, asynchronous, active high |
| width_i | input | 22 | Width word: [21:6] coarse blocks of 64, [5:0] fine cycles |
| pulse_o | output | 1 | Pulse output |
| pulse_no | output | 1 | Complemented pulse output |

## Verification
On every cycle, the assertions hold the following behaviours:
- an active pulse continues unless it reaches its count or is stopped;
- a stop request moves the block straight into recovery;
- recovery never jumps straight into a new pulse;
- the remaining-cycle count drops by exactly one per running cycle.

Some behaviours can only be shown by the bench's scenarios, because they span whole pulses:
- the three-edge trigger latency;
- the exact pulse length for each coarse and fine combination, including zero and the 64-cycle boundary;
- the one-cycle boundary between a discarded and an accepted trigger at the end of a full and of a stopped pulse.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_RECOV  = 2'd2
  } pg_state_e;
endpackage

// File: rtl/pgen_sync.sv
module pgen_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic [WIDTH-1:0] d;
    if (i == 0) begin : g_first
      assign d = async_i;
    end else begin : g_next
      assign d = stg_q[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= '0;
      else         stg_q[i] <= d;
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/pgen_width_cnt.sv
module pgen_width_cnt #(
  parameter int unsigned COARSE_W = 16,
  parameter int unsigned FINE_W   = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                run_i,
  input  logic [COARSE_W-1:0] coarse_i,
  input  logic [FINE_W-1:0]   fine_i,
  output logic                last_o
);
  localparam int unsigned REM_W = COARSE_W + FINE_W;

  logic [COARSE_W-1:0] coarse_q;
  logic [FINE_W-1:0]   fine_q;
  logic [REM_W-1:0]    rem;

  assign rem = {coarse_q, fine_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coarse_q <= '0;
      fine_q   <= '0;
    end else if (load_i) begin
      coarse_q <= coarse_i;
      fine_q   <= fine_i;
    end else if (run_i) begin
      // borrow from the coarse field when the fine field is exhausted
      if (fine_q == '0) begin
        coarse_q <= coarse_q - 1'b1;
        fine_q   <= '1;
      end else begin
        fine_q   <= fine_q - 1'b1;
      end
    end
  end

  // one cycle left (or a zero word): the pulse ends on this edge
  assign last_o = (coarse_q == '0) && (fine_q <= FINE_W'(1));

  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i) |=> (rem == $past(rem) - 1'b1));
endmodule

// File: rtl/pgen_ctrl.sv
module pgen_ctrl
  import pgen_pkg::*;
#(
  parameter int unsigned COARSE_W  = 16,
  parameter int unsigned FINE_W    = 6,
  parameter int unsigned RECOV_CYC = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       trig_s_i,
  input  logic                       stop_s_i,
  input  logic [COARSE_W+FINE_W-1:0] width_i,
  output logic                       pulse_o,
  output logic                       pulse_no
);
  localparam int unsigned REC_W = $clog2(RECOV_CYC + 1);

  pg_state_e        state_q;
  logic [REC_W-1:0] rec_q;
  logic             trig_d_q;
  logic             trig_edge;
  logic             load;
  logic             run;
  logic             last;

  assign trig_edge = trig_s_i & ~trig_d_q;
  assign load      = (state_q == ST_IDLE) && trig_edge;
  assign run       = (state_q == ST_ACTIVE) && !last && !stop_s_i;

  pgen_width_cnt #(
    .COARSE_W(COARSE_W),
    .FINE_W  (FINE_W)
  ) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .run_i   (run),
    .coarse_i(width_i[COARSE_W+FINE_W-1:FINE_W]),
    .fine_i  (width_i[FINE_W-1:0]),
    .last_o  (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      rec_q    <= '0;
      trig_d_q <= 1'b0;
    end else begin
      trig_d_q <= trig_s_i;
      unique case (state_q)
        ST_IDLE: begin
          if (trig_edge) state_q <= ST_ACTIVE;
        end
        ST_ACTIVE: begin
          if (stop_s_i || last) begin
            state_q <= ST_RECOV;
            rec_q   <= REC_W'(RECOV_CYC - 1);
          end
        end
        ST_RECOV: begin
          if (rec_q == '0) state_q <= ST_IDLE;
          else             rec_q   <= rec_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pulse_o  = (state_q == ST_ACTIVE);
  assign pulse_no = (state_q != ST_ACTIVE);

  assert_lockout_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACTIVE && !stop_s_i && !last) |=> (state_q == ST_ACTIVE));

  assert_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACTIVE && stop_s_i) |=> (state_q == ST_RECOV));

  assert_recov_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECOV) |=> (state_q != ST_ACTIVE));

  assert_rec_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECOV) |-> (rec_q < REC_W'(RECOV_CYC)));

  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> $past(trig_s_i));
endmodule

// File: rtl/trig_pulse_gen.sv
module trig_pulse_gen #(
  parameter int unsigned WORD_W      = 22,
  parameter int unsigned FINE_W      = 6,
  parameter int unsigned RECOV_CYC   = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic              stop_i,
  input  logic [WORD_W-1:0] width_i,
  output logic              pulse_o,
  output logic              pulse_no
);
  localparam int unsigned COARSE_W = WORD_W - FINE_W;

  logic [1:0] sync_q;

  pgen_sync #(
    .WIDTH (2),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({stop_i, trig_i}),
    .sync_o (sync_q)
  );

  pgen_ctrl #(
    .COARSE_W (COARSE_W),
    .FINE_W   (FINE_W),
    .RECOV_CYC(RECOV_CYC)
  ) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_s_i(sync_q[0]),
    .stop_s_i(sync_q[1]),
    .width_i (width_i),
    .pulse_o (pulse_o),
    .pulse_no(pulse_no)
  );
endmodule

// File: tb/trig_pulse_gen_test.sv
module trig_pulse_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic        stop = 1'b0;
  logic [21:0] width = '0;
  logic        pulse, pulse_n;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  trig_pulse_gen uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .trig_i  (trig),
    .stop_i  (stop),
    .width_i (width),
    .pulse_o (pulse),
    .pulse_no(pulse_n)
  );

  function automatic int exp_len(logic [21:0] w);
    int v = int'(w[21:6]) * 64 + int'(w[5:0]);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R11 on every sample
  always @(negedge clk) begin
    if (rst_n && !done && (pulse_n !== ~pulse)) begin
      errors++;
      $display("FAIL R11 actual=%0d expected=%0d", pulse_n, ~pulse);
    end
  end

  // raise trigger, wait for rise, measure length
  task automatic fire(input logic [21:0] w, output int lat, output int len);
    @(negedge clk);
    width = w;
    trig  = 1'b1;
    lat = 0;
    len = 0;
    while (!pulse && lat < 12) begin
      @(negedge clk);
      lat++;
    end
    if (pulse) begin
      len = 1;
      trig = 1'b0;
      forever begin
        @(negedge clk);
        if (pulse) len++;
        else break;
      end
    end
    trig = 1'b0;
  endtask

  task automatic quiet(int n, string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pulse) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  initial begin
    int lat, len, cnt;
    logic [21:0] w;
    logic [21:0] corners [8] = '{22'd0, 22'd1, 22'd2, 22'd63, 22'd64, 22'd65, 22'd127, 22'd128};
    void'($urandom(32'h1bad5eed));

    repeat (3) @(negedge clk);
    chk(pulse == 1'b0 && pulse_n == 1'b1, "R1 in reset", pulse, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(pulse == 1'b0 && pulse_n == 1'b1, "R1 after reset", pulse, 0);

    // R2 R3 R4 corners
    foreach (corners[i]) begin
      fire(corners[i], lat, len);
      chk(lat == 3, "R2 latency", lat, 3);
      chk(len == exp_len(corners[i]), (corners[i] == 0) ? "R4 zero word" : "R3 width", len, exp_len(corners[i]));
      repeat (4) @(negedge clk);
    end

    // R12: stop while idle
    @(negedge clk); stop = 1'b1;
    repeat (5) @(negedge clk); stop = 1'b0;
    repeat (4) @(negedge clk);
    fire(22'd40, lat, len);
    chk(lat == 3 && len == 40, "R12 stop idle", len, 40);
    repeat (4) @(negedge clk);

    // R5 R6 R10: retrigger and width change inside pulse
    @(negedge clk); width = 22'd100; trig = 1'b1;
    lat = 0;
    while (!pulse && lat < 12) begin @(negedge clk); lat++; end
    len = 1;
    repeat (10) begin @(negedge clk); if (pulse) len++; end
    width = 22'd5; trig = 1'b0;
    repeat (2) begin @(negedge clk); if (pulse) len++; end
    trig = 1'b1;
    forever begin @(negedge clk); if (pulse) len++; else break; end
    chk(len == 100, "R5 R6 length kept", len, 100);
    quiet(12, "R10 held trigger");
    trig = 1'b0;
    repeat (4) @(negedge clk);

    // R7: trigger in last high cycle is dropped
    @(negedge clk); width = 22'd10; trig = 1'b1;
    while (!pulse) @(negedge clk);
    trig = 1'b0;
    cnt = 1;
    while (cnt < 10) begin @(negedge clk); if (pulse) cnt++; end
    trig = 1'b1;
    @(negedge clk);
    chk(pulse == 1'b0, "R7 end", pulse, 0);
    quiet(12, "R7 dropped in window");
    trig = 1'b0;
    repeat (4) @(negedge clk);

    // R7: trigger one cycle later is taken
    @(negedge clk); width = 22'd10; trig = 1'b1;
    while (!pulse) @(negedge clk);
    trig = 1'b0;
    while (pulse) @(negedge clk);
    trig = 1'b1;
    lat = 0;
    while (!pulse && lat < 12) begin @(negedge clk); lat++; end
    chk(lat == 3, "R7 accepted after window", lat, 3);
    trig = 1'b0;
    while (pulse) @(negedge clk);
    repeat (4) @(negedge clk);

    // R8 R9: stop cuts pulse; trigger in last high cycle dropped
    @(negedge clk); width = 22'd300; trig = 1'b1;
    while (!pulse) @(negedge clk);
    trig = 1'b0;
    repeat (20) @(negedge clk);
    stop = 1'b1;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (pulse) begin
        cnt++;
        if (cnt == 2) trig = 1'b1;
      end else break;
    end
    chk(cnt == 2, "R8 stop latency", cnt, 2);
    stop = 1'b0;
    quiet(12, "R9 dropped after stop");
    trig = 1'b0;
    repeat (4) @(negedge clk);
    fire(22'd7, lat, len);
    chk(lat == 3 && len == 7, "R9 accepted after stop", len, 7);
    repeat (4) @(negedge clk);

    // random widths
    for (int i = 0; i < 40; i++) begin
      w = {14'd0, 2'($urandom_range(0, 3)), 6'($urandom)};
      fire(w, lat, len);
      chk(lat == 3, "R2 random latency", lat, 3);
      chk(len == exp_len(w), "R3 random width", len, exp_len(w));
      repeat (2 + $urandom_range(0, 3)) @(negedge clk);
    end

    chk(pulse_n == ~pulse, "R11 final", pulse_n, ~pulse);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule